// File: doc/BRIEF.md
# Sticky Level Interrupt Bank

The block watches a group of input pins (eight by default) and turns an active level on any of them into a pending flag that stays set until software clears it. Each pin first passes through a short flip-flop synchroniser. A per-channel polarity bit then decides whether a high or a low level counts as active. Once a channel sees its active level, its pending flag holds even after the pin returns to the idle level. A per-channel enable gates the pending flags into a masked view, and the single interrupt output is high while any masked flag is set.

Software reaches the block through a plain register port. Writes take effect on the next rising clock edge. Reads are combinational from the address. The port has these registers: enable, raw pending, masked pending, clear (write one to clear), polarity, and a mode register that only stores a value. The block does not return the live pin levels through the register port.

Each channel runs a two-state machine. `CH_IDLE` moves to `CH_PEND` on the transition *arm*, when the synchronised level is active and no clear is written for that channel in that cycle. `CH_PEND` moves back to `CH_IDLE` on the transition *ack*, when a one is written to that channel's clear bit. In every other case each state holds (*wait* in `CH_IDLE`, *hold* in `CH_PEND`). A clear always wins over a new arrival.

Top module: `lvl_irq_bank`

## Requirements
- R1: While reset is asserted and right after it, every register reads 0, every pending flag is 0 and `irq` is low.
- R2: Each pin passes through two synchroniser stages. A pin that turns active just after a rising edge leaves its raw bit at 0 after two rising edges and sets the bit on the third.
- R3: In the polarity register (offset 0x10), bit i = 0 makes channel i active on a high pin and bit i = 1 makes it active on a low pin. A channel whose active level is present and that receives no clear gets its raw bit set.
- R4: Raw pending (offset 0x04, bit i = channel i) is sticky. Once set, a bit stays 1 after the pin returns to its idle level, until the bit is cleared.
- R5: In the enable register (offset 0x00), bit i = 1 unmasks channel i. Masked pending (offset 0x08) equals raw AND enable, and `irq` is the OR of the masked bits. Raw bits latch whatever the enable value.
- R6: Writing the clear register (offset 0x0C) clears exactly the channels whose written bit is 1. Bits written as 0 leave their channels untouched. Reading offset 0x0C returns 0.
- R7: If the active level is still present when a clear is written, the raw bit reads 0 in the cycle after the write and 1 again one cycle later.
- R8: If a clear and a newly synchronised active level reach a channel at the same edge, the clear wins. The bit reads 0 after that edge and sets on the following edge.
- R9: The mode register (offset 0x14) stores all eight written bits and returns them on a read. Its value has no effect on detection.
- R10: Writes to raw pending or masked pending are ignored. Offsets outside the six registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | NCH (8) | Write data, bit i belongs to channel i |
| reg_rdata | output | NCH (8) | Read data for the register at `reg_addr` (combinational) |
| pin_in | input | NCH (8) | Level inputs, asynchronous to `clk` |
| irq | output | 1 | High while any enabled channel is pending |

## Verification
The collision that matters is a one-written clear bit reaching a channel in the very cycle that channel's synchronised input becomes active. The bench raises a pin and waits exactly two edges, so the second synchroniser stage turns active at the edge where the clear write is also presented. The bench then reads raw pending right after that edge and expects 0, and one edge later expects 1. A design where the set wins would show 1 on the first read. A second case writes a clear to a channel whose level never went away and looks for the same one-cycle gap before the bit returns.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    // Register byte offsets; software decodes these positions.
    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_RAW    = 8'h04;
    localparam logic [7:0] OFS_MASKED = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_POLAR  = 8'h10;
    localparam logic [7:0] OFS_MODE   = 8'h14;

    // Per-channel pending state machine.
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

    // Register select produced by the address decoder.
    typedef enum logic [2:0] {
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_POLAR,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_ENABLE: s = SEL_ENABLE;
            OFS_RAW:    s = SEL_RAW;
            OFS_MASKED: s = SEL_MASKED;
            OFS_CLEAR:  s = SEL_CLEAR;
            OFS_POLAR:  s = SEL_POLAR;
            OFS_MODE:   s = SEL_MODE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lvl_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
module lvl_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[LAST];

endmodule

// File: rtl/lvl_chan.sv
// One channel: two-state pending machine, clear has priority over arm.
module lvl_chan
    import lvl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pend
);

    ch_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm, ack, wait, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (hit && !clr) state_d = CH_PEND;   // arm
                else             state_d = CH_IDLE;   // wait
            end
            CH_PEND: begin
                if (clr) state_d = CH_IDLE;           // ack
                else     state_d = CH_PEND;           // hold
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CH_PEND: pend = 1'b1;
            default: pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/lvl_regs.sv
// Register file: enable, polarity, mode storage, clear pulse, read mux.
module lvl_regs
    import lvl_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    reg_wdata,
    input  logic [NCH-1:0]    raw,
    output logic [NCH-1:0]    reg_rdata,
    output logic [NCH-1:0]    en,
    output logic [NCH-1:0]    pol,
    output logic [NCH-1:0]    clr,
    output logic [NCH-1:0]    masked
);

    logic [7:0]     addr8;
    reg_sel_e       sel;
    logic [NCH-1:0] en_q, pol_q, mode_q;

    assign addr8 = 8'(reg_addr);
    assign sel   = decode_addr(addr8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            mode_q <= '0;
        end else if (reg_we) begin
            unique case (sel)
                SEL_ENABLE: en_q   <= reg_wdata;
                SEL_POLAR:  pol_q  <= reg_wdata;
                SEL_MODE:   mode_q <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // Write-one-to-clear pulse, seen by the channels at the same edge.
    assign clr    = (reg_we && sel == SEL_CLEAR) ? reg_wdata : '0;
    assign masked = raw & en_q;
    assign en     = en_q;
    assign pol    = pol_q;

    always_comb begin
        unique case (sel)
            SEL_ENABLE: reg_rdata = en_q;
            SEL_RAW:    reg_rdata = raw;
            SEL_MASKED: reg_rdata = masked;
            SEL_POLAR:  reg_rdata = pol_q;
            SEL_MODE:   reg_rdata = mode_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lvl_irq_bank.sv
// Top: sticky level interrupt bank.
module lvl_irq_bank #(
    parameter int NCH         = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    reg_wdata,
    output logic [NCH-1:0]    reg_rdata,
    input  logic [NCH-1:0]    pin_in,
    output logic              irq
);

    logic [NCH-1:0] sync_w, hit_w, clr_w, raw_q, en_w, pol_w, masked_w;

    lvl_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_w)
    );

    // Polarity 0: active high; 1: active low.
    assign hit_w = sync_w ^ pol_w;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            lvl_chan u_chan (
                .clk  (clk),
                .rst_n(rst_n),
                .hit  (hit_w[c]),
                .clr  (clr_w[c]),
                .pend (raw_q[c])
            );
        end
    endgenerate

    lvl_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .raw      (raw_q),
        .reg_rdata(reg_rdata),
        .en       (en_w),
        .pol      (pol_w),
        .clr      (clr_w),
        .masked   (masked_w)
    );

    assign irq = |masked_w;

endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] pend,
    input logic [NCH-1:0] hit,
    input logic [NCH-1:0] clr
);

    // R1: reset leaves every channel idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));

    // R2: a flag only rises after an active synchronised level
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0));

    // R3: active level without clear leaves the flag set
    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~clr) != '0) |=> ((pend & $past(hit & ~clr)) == $past(hit & ~clr)));

    // R4: a set flag holds unless cleared
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

    // R8: clear wins over any arrival at the same edge
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((pend & $past(clr)) == '0));

endmodule

bind lvl_irq_bank lvl_irq_bank_chk #(.NCH(NCH)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (raw_q),
    .hit  (hit_w),
    .clr  (clr_w)
);

// File: tb/tb_lvl_irq_bank.sv
module tb_lvl_irq_bank;

    localparam int NCH    = 8;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_EN   = 5'h00;
    localparam logic [ADDR_W-1:0] A_RAW  = 5'h04;
    localparam logic [ADDR_W-1:0] A_MSK  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_POL  = 5'h10;
    localparam logic [ADDR_W-1:0] A_MODE = 5'h14;

    // {polarity, enable, pins, exp raw, exp masked, exp irq}
    localparam int NVEC = 6;
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h00, 8'hFF, 8'h5A, 8'h5A, 8'h5A, 8'h01},
        {8'hFF, 8'h0F, 8'h5A, 8'hA5, 8'h05, 8'h01},
        {8'h0F, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'h00, 8'h81, 8'h81, 8'h00, 8'h00},
        {8'h3C, 8'h3C, 8'hC3, 8'hFF, 8'h3C, 8'h01},
        {8'h00, 8'h80, 8'h80, 8'h80, 8'h80, 8'h01}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [NCH-1:0]    reg_wdata = '0;
    logic [NCH-1:0]    reg_rdata;
    logic [NCH-1:0]    pin_in = '0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lvl_irq_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pin_in   (pin_in),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pv, ev, iv;

        // R1: reset state
        idle(3);
        #1 check("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        rd(A_EN, d);   check("R1 enable", d, 8'h00);
        rd(A_RAW, d);  check("R1 raw", d, 8'h00);
        rd(A_MSK, d);  check("R1 masked", d, 8'h00);
        rd(A_POL, d);  check("R1 polarity", d, 8'h00);
        rd(A_MODE, d); check("R1 mode", d, 8'h00);
        #1 check("R1 irq", {7'd0, irq}, 8'h00);

        // Table walk: R3 polarity, R5 enable/masked/irq
        for (int v = 0; v < NVEC; v++) begin
            pv = VEC[v][47:40]; ev = VEC[v][39:32];
            wr(A_POL, pv);
            wr(A_EN, ev);
            @(negedge clk); pin_in = VEC[v][31:24];
            idle(4);
            wr(A_CLR, 8'hFF);
            idle(4);
            rd(A_RAW, d); check($sformatf("R3 vec%0d raw", v), d, VEC[v][23:16]);
            rd(A_MSK, d); check($sformatf("R5 vec%0d masked", v), d, VEC[v][15:8]);
            iv = {7'd0, irq};
            check($sformatf("R5 vec%0d irq", v), iv, VEC[v][7:0]);
        end

        // Quiet baseline
        @(negedge clk); pin_in = '0;
        wr(A_POL, 8'h00);
        wr(A_EN, 8'hFF);
        idle(4);
        wr(A_CLR, 8'hFF);
        idle(2);

        // R2: synchroniser latency
        @(negedge clk); reg_addr = A_RAW;
        @(negedge clk); pin_in = 8'h01;
        @(negedge clk); @(negedge clk);
        #1 check("R2 after two edges", reg_rdata, 8'h00);
        @(negedge clk);
        #1 check("R2 after three edges", reg_rdata, 8'h01);

        // R4: sticky after pin returns idle
        @(negedge clk); pin_in = 8'h05;
        idle(4);
        @(negedge clk); pin_in = 8'h01;
        idle(4);
        rd(A_RAW, d); check("R4 sticky", d, 8'h05);

        // R6: selective clear; zero bits untouched; clear reads 0
        wr(A_CLR, 8'h04);
        rd(A_RAW, d); check("R6 selective clear", d, 8'h01);
        wr(A_CLR, 8'h00);
        rd(A_RAW, d); check("R6 zero write", d, 8'h01);
        rd(A_CLR, d); check("R6 clear reads zero", d, 8'h00);

        // R7: clear while level still present
        @(negedge clk); reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0; reg_wdata = '0; reg_addr = A_RAW;
        #1 check("R7 gap after clear", reg_rdata, 8'h00);
        @(negedge clk);
        #1 check("R7 reassert", reg_rdata, 8'h01);

        // R8: clear and arrival at the same edge
        @(negedge clk); pin_in = 8'h03;
        @(negedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 8'h02;
        @(negedge clk); reg_we = 1'b0; reg_wdata = '0; reg_addr = A_RAW;
        #1 check("R8 clear wins", reg_rdata, 8'h01);
        @(negedge clk);
        #1 check("R8 set next edge", reg_rdata, 8'h03);

        // R5: raw latches while masked, enabling raises irq
        wr(A_EN, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        wr(A_CLR, 8'hFF);
        @(negedge clk); pin_in = 8'h40;
        idle(4);
        rd(A_RAW, d); check("R5 raw while masked", d, 8'h40);
        #1 check("R5 irq masked", {7'd0, irq}, 8'h00);
        wr(A_EN, 8'h40);
        #1 check("R5 irq after enable", {7'd0, irq}, 8'h01);

        // R9: mode stores bits, no effect on detection
        @(negedge clk); pin_in = 8'h00;
        wr(A_CLR, 8'hFF);
        wr(A_MODE, 8'hA5);
        rd(A_MODE, d); check("R9 mode readback", d, 8'hA5);
        @(negedge clk); pin_in = 8'h20;
        idle(4);
        rd(A_RAW, d); check("R9 detection unchanged", d, 8'h20);

        // R10: read-only registers ignore writes; unmapped offsets read 0
        wr(A_RAW, 8'h00);
        rd(A_RAW, d); check("R10 raw write ignored", d, 8'h20);
        wr(A_MSK, 8'hFF);
        rd(A_EN, d);  check("R10 masked write ignored", d, 8'h40);
        rd(A_RAW, d); check("R10 raw after masked write", d, 8'h20);
        rd(5'h18, d); check("R10 unmapped 0x18", d, 8'h00);
        rd(5'h02, d); check("R10 unmapped 0x02", d, 8'h00);

        // R1: reset mid-run returns everything to zero
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; pin_in = 8'h00;
        rd(A_RAW, d); check("R1 raw after reset", d, 8'h00);
        rd(A_MODE, d); check("R1 mode after reset", d, 8'h00);

        finish_run();
    end

endmodule